// File: doc/BRIEF.md
# Bridge-Steering PWM Output Generator

The block turns one pulse-width-modulated signal into drive for four output channels, A to D, so that one PWM source can run a single load, a half-bridge or a full bridge in either direction. It watches an external free-running timer count and a period value. At the end of each period it loads new settings and starts a new pulse. The pulse ends once the duty count has elapsed. The 10-bit duty value is assembled from an 8-bit upper part and a 2-bit lower part.

A 2-bit steering field picks how the pulse reaches the channels. A 2-bit polarity field picks the active level of the A/C pair and of the B/D pair. In half-bridge mode A and B form a complementary pair, and a dead-band count delays every turn-on edge so that both switches are never on together. Each channel has an enable output. It tells the pad logic whether the block drives that pin or leaves it as general I/O.

All settings (duty, steering, polarity, dead-band) are shadowed. They take effect only at the period boundary, which is the clock cycle in which the timer count equals the period value. Timer, shutdown logic and register access sit outside the block.

Top module: `steer_pwm_top`

## Requirements
- R1: After reset every channel output is 0, the enable word is 4'b0001 (only A driven), and this holds until the first period boundary.
- R2: The period is periodVal+1 clock cycles. In steering 2'b00 (single) channel A is active for exactly min(duty, periodVal+1) cycles of each period. Channels B, C and D have enable 0 and stay at their inactive level.
- R3: A duty of 0 keeps the modulated channel inactive for the whole period. A duty of periodVal+1 or more keeps it active for the whole period.
- R4: The duty value is {dutyHi[7:0], dutyLo[1:0]}, so dutyLo carries the two least significant bits.
- R5: In steering 2'b01 (forward) D is modulated, A is held active, and B and C are held inactive.
- R6: In steering 2'b11 (reverse) B is modulated, C is held active, and A and D are held inactive.
- R7: In steering 2'b10 (half-bridge) A follows the pulse and B follows its complement. Each turn-on edge is delayed by deadCnt cycles and turn-off edges are not delayed. Per period, A is active max(0, d-deadCnt) cycles and B is active max(0, P-d-deadCnt) cycles, where P is the period length and d is the duty (d < P).
- R8: A and B are never active in the same cycle.
- R9: polSel[1]=1 makes A and C active-low and polSel[0]=1 makes B and D active-low. Inversion is applied last, so a held-inactive or released channel drives the inactive level of its pair.
- R10: Changes to duty, steering, polarity or dead-band between period boundaries have no effect on outputs or enables until the next boundary.
- R11: The enable word (bit 0 = A to bit 3 = D) is 4'b0001 in single mode, 4'b0011 in half-bridge mode and 4'b1111 in both full-bridge modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tmrVal | input | 10 | Free-running timer count |
| periodVal | input | 10 | Last timer count of a period |
| dutyHi | input | 8 | Upper eight duty bits |
| dutyLo | input | 2 | Lower two duty bits |
| cfgSel | input | 2 | Steering: 00 single, 01 forward, 10 half-bridge, 11 reverse |
| polSel | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| deadCnt | input | 6 | Dead-band delay in clock cycles |
| chOut | output | 4 | Channel levels, bit 0 = A to bit 3 = D |
| chEn | output | 4 | Channel drive enables, same bit order |

## Verification
A corrupted shadow register shows as a wrong active-cycle count or a wrong enable word over the next full period. It can also show as settings that move mid-period, visible within one period of the write. A stuck pulse flag or dead-band counter changes the per-period active counts of the modulated channels, or makes A and B active together, within the first period after a boundary. A bad polarity path flips the held and released channels for the whole period. The bench therefore compares per-period active counts, enables and overlap against values derived from duty, period and dead-band.

// File: rtl/steer_pwm_pkg.sv
package steer_pwm_pkg;

  typedef enum logic [1:0] {
    CFG_SINGLE = 2'b00,
    CFG_FWD    = 2'b01,
    CFG_HALF   = 2'b10,
    CFG_REV    = 2'b11
  } steerCfg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // period boundary: take shadow values
    logic setBase;  // start a pulse
    logic clrBase;  // end a pulse
  } pwmStrobe_t;

endpackage

// File: rtl/steer_pwm_ctrl.sv
module steer_pwm_ctrl
  import steer_pwm_pkg::*;
#(
  parameter int TMR_W = 10
) (
  input  logic [TMR_W-1:0] tmrVal,
  input  logic [TMR_W-1:0] perVal,
  input  logic [TMR_W-1:0] dutyNext,
  input  logic [TMR_W-1:0] dutyCur,
  output pwmStrobe_t       strobe
);

  logic periodEnd;
  logic dutyHit;

  assign periodEnd = (tmrVal == perVal);
  // last cycle of the pulse: the timer count one below the duty
  assign dutyHit   = (dutyCur != '0) && (tmrVal == (dutyCur - TMR_W'(1)));

  always_comb begin
    strobe.load    = periodEnd;
    strobe.setBase = periodEnd && (dutyNext != '0);
    strobe.clrBase = periodEnd ? (dutyNext == '0) : dutyHit;
  end

endmodule

// File: rtl/steer_pwm_dp.sv
module steer_pwm_dp
  import steer_pwm_pkg::*;
#(
  parameter int TMR_W  = 10,
  parameter int DEAD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [TMR_W-1:0]  dutyNext,
  input  steerCfg_e         cfgNext,
  input  logic [1:0]        polNext,
  input  logic [DEAD_W-1:0] deadNext,
  output logic [TMR_W-1:0]  dutyCur,
  output logic [3:0]        chOut,
  output logic [3:0]        chEn
);

  localparam int NCH   = 4;
  localparam int NDEAD = 2;  // channels A and B carry dead-band

  steerCfg_e         cfgS;
  logic [1:0]        polS;
  logic [DEAD_W-1:0] deadS;
  logic              baseQ;
  logic [NCH-1:0]    rawAct;
  logic [NCH-1:0]    enNext;
  logic [NCH-1:0]    invNext;
  logic [NCH-1:0]    actQ;
  logic [NCH-1:0]    invQ;
  logic [NCH-1:0]    enQ;

  // shadow registers, loaded only at the period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyCur <= '0;
      cfgS    <= CFG_SINGLE;
      polS    <= '0;
      deadS   <= '0;
    end else if (strobe.load) begin
      dutyCur <= dutyNext;
      cfgS    <= cfgNext;
      polS    <= polNext;
      deadS   <= deadNext;
    end
  end

  // base pulse flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               baseQ <= 1'b0;
    else if (strobe.setBase) baseQ <= 1'b1;
    else if (strobe.clrBase) baseQ <= 1'b0;
  end

  // steering of the base pulse into active levels
  always_comb begin
    unique case (cfgS)
      CFG_SINGLE: begin rawAct = {3'b000, baseQ};        enNext = 4'b0001; end
      CFG_FWD:    begin rawAct = {baseQ, 2'b00, 1'b1};   enNext = 4'b1111; end
      CFG_HALF:   begin rawAct = {2'b00, ~baseQ, baseQ}; enNext = 4'b0011; end
      default:    begin rawAct = {1'b0, 1'b1, baseQ, 1'b0}; enNext = 4'b1111; end
    endcase
    invNext = {polS[0], polS[1], polS[0], polS[1]};
  end

  // per-channel turn-on delay
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit HAS_DEAD = (ch < NDEAD);
    logic [DEAD_W-1:0] holdCnt;
    logic              useDead;

    assign useDead = HAS_DEAD && (cfgS == CFG_HALF);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdCnt  <= '0;
        actQ[ch] <= 1'b0;
      end else if (!rawAct[ch]) begin
        holdCnt  <= '0;
        actQ[ch] <= 1'b0;
      end else if (!useDead || (holdCnt >= deadS)) begin
        actQ[ch] <= 1'b1;
      end else begin
        holdCnt  <= holdCnt + DEAD_W'(1);
      end
    end
  end

  // enables and polarity travel in the same stage as the levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 4'b0001;
      invQ <= '0;
    end else begin
      enQ  <= enNext;
      invQ <= invNext;
    end
  end

  assign chOut = actQ ^ invQ;
  assign chEn  = enQ;

  // R3
  dutyZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (dutyNext == '0)) |=> !baseQ);

  // R2
  pulseStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (dutyNext != '0)) |=> baseQ);

  // R8
  noOverlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgS == CFG_HALF) |-> !(actQ[0] && actQ[1]));

  // R10
  cfgHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> $stable(cfgS));

  // R11
  enHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load, 2) |-> $stable(chEn));

endmodule

// File: rtl/steer_pwm_top.sv
module steer_pwm_top
  import steer_pwm_pkg::*;
#(
  parameter int TMR_W     = 10,
  parameter int DUTY_LO_W = 2,
  parameter int DEAD_W    = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [TMR_W-1:0]           tmrVal,
  input  logic [TMR_W-1:0]           periodVal,
  input  logic [TMR_W-DUTY_LO_W-1:0] dutyHi,
  input  logic [DUTY_LO_W-1:0]       dutyLo,
  input  logic [1:0]                 cfgSel,
  input  logic [1:0]                 polSel,
  input  logic [DEAD_W-1:0]          deadCnt,
  output logic [3:0]                 chOut,
  output logic [3:0]                 chEn
);

  logic [TMR_W-1:0] dutyNext;
  logic [TMR_W-1:0] dutyCur;
  pwmStrobe_t       strobe;

  assign dutyNext = {dutyHi, dutyLo};

  steer_pwm_ctrl #(.TMR_W(TMR_W)) i_ctrl (
    .tmrVal   (tmrVal),
    .perVal   (periodVal),
    .dutyNext (dutyNext),
    .dutyCur  (dutyCur),
    .strobe   (strobe)
  );

  steer_pwm_dp #(.TMR_W(TMR_W), .DEAD_W(DEAD_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dutyNext (dutyNext),
    .cfgNext  (steerCfg_e'(cfgSel)),
    .polNext  (polSel),
    .deadNext (deadCnt),
    .dutyCur  (dutyCur),
    .chOut    (chOut),
    .chEn     (chEn)
  );

endmodule

// File: tb/test_steer_pwm_top.sv
`timescale 1ns/1ps
module test_steer_pwm_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] tmrVal = '0;
  logic [9:0] perReg = 10'd63;
  logic [7:0] dutyHi = '0;
  logic [1:0] dutyLo = '0;
  logic [1:0] cfgSel = '0;
  logic [1:0] polSel = '0;
  logic [5:0] deadCnt = '0;
  logic [3:0] chOut;
  logic [3:0] chEn;

  int errCnt = 0;
  int chkCnt = 0;
  int hiCnt[4];
  int bothCnt;
  int enBad;
  logic [1:0] polCur = '0;

  always #4 clk = ~clk;

  steer_pwm_top i_steer_pwm_top (
    .clk(clk), .rstN(rstN), .tmrVal(tmrVal), .periodVal(perReg),
    .dutyHi(dutyHi), .dutyLo(dutyLo), .cfgSel(cfgSel), .polSel(polSel),
    .deadCnt(deadCnt), .chOut(chOut), .chEn(chEn)
  );

  // free-running timer wrapping at the period value
  initial begin
    forever @(negedge clk) tmrVal <= (tmrVal >= perReg) ? 10'd0 : tmrVal + 10'd1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyCfg(input logic [1:0] cfg, input logic [1:0] pol,
                          input int duty, input int dead);
    cfgSel  = cfg;
    polSel  = pol;
    polCur  = pol;
    dutyHi  = duty[9:2];
    dutyLo  = duty[1:0];
    deadCnt = dead[5:0];
  endtask

  // advance to the first sample of a period (timer count 0 seen at the last edge)
  task automatic syncStart();
    do @(negedge clk); while (tmrVal != 10'd0);
  endtask

  // count one period starting at the current sample
  task automatic measure(input logic [3:0] enExp);
    for (int c = 0; c < 4; c++) hiCnt[c] = 0;
    bothCnt = 0;
    enBad = 0;
    for (int i = 0; i <= int'(perReg); i++) begin
      if (i > 0) @(negedge clk);
      for (int c = 0; c < 4; c++) if (chOut[c]) hiCnt[c]++;
      if ((chOut[0] ^ polCur[1]) && (chOut[1] ^ polCur[0])) bothCnt++;
      if (chEn != enExp) enBad++;
    end
  endtask

  task automatic expectWin(input string tag, input int a, input int b,
                           input int c, input int d);
    chk(hiCnt[0] == a, {tag, " chA"}, hiCnt[0], a);
    chk(hiCnt[1] == b, {tag, " chB"}, hiCnt[1], b);
    chk(hiCnt[2] == c, {tag, " chC"}, hiCnt[2], c);
    chk(hiCnt[3] == d, {tag, " chD"}, hiCnt[3], d);
    chk(enBad == 0, {tag, " enable"}, enBad, 0);
    chk(bothCnt == 0, {tag, " overlap R8"}, bothCnt, 0);
  endtask

  task automatic runCase(input string tag, input logic [1:0] cfg, input logic [1:0] pol,
                         input int duty, input int dead, input logic [3:0] en,
                         input int a, input int b, input int c, input int d);
    @(negedge clk);
    applyCfg(cfg, pol, duty, dead);
    syncStart();
    measure(en);
    expectWin(tag, a, b, c, d);
  endtask

  task automatic testReset();
    applyCfg(2'b01, 2'b11, 300, 5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(chOut == 4'b0000, "R1 outputs after reset", int'(chOut), 0);
    chk(chEn == 4'b0001, "R1 enables after reset", int'(chEn), 1);
  endtask

  task automatic testSingle();
    runCase("R2 R4 R11 single duty37", 2'b00, 2'b00, 37, 0, 4'b0001, 37, 0, 0, 0);
    runCase("R4 single duty3 low bits", 2'b00, 2'b00, 3, 0, 4'b0001, 3, 0, 0, 0);
  endtask

  task automatic testDutyEdges();
    runCase("R3 duty zero", 2'b00, 2'b00, 0, 0, 4'b0001, 0, 0, 0, 0);
    runCase("R3 duty above period", 2'b00, 2'b00, 100, 0, 4'b0001, 64, 0, 0, 0);
  endtask

  task automatic testBridges();
    runCase("R5 R11 forward", 2'b01, 2'b00, 21, 0, 4'b1111, 64, 0, 0, 21);
    runCase("R6 R11 reverse", 2'b11, 2'b00, 10, 0, 4'b1111, 0, 10, 64, 0);
  endtask

  task automatic testHalf();
    runCase("R7 R8 R11 half dead3", 2'b10, 2'b00, 30, 3, 4'b0011, 27, 31, 0, 0);
    runCase("R7 half dead0", 2'b10, 2'b00, 30, 0, 4'b0011, 30, 34, 0, 0);
    runCase("R7 half dead exceeds", 2'b10, 2'b00, 30, 40, 4'b0011, 0, 0, 0, 0);
  endtask

  task automatic testPolarity();
    runCase("R9 forward AC low", 2'b01, 2'b10, 21, 0, 4'b1111, 0, 0, 64, 21);
    runCase("R9 single BD low", 2'b00, 2'b01, 37, 0, 4'b0001, 37, 64, 0, 64);
    runCase("R9 R8 half both low", 2'b10, 2'b11, 30, 3, 4'b0011, 37, 33, 64, 64);
  endtask

  task automatic testShadow();
    runCase("R10 baseline", 2'b00, 2'b00, 37, 0, 4'b0001, 37, 0, 0, 0);
    syncStart();
    applyCfg(2'b01, 2'b00, 10, 0);  // written mid-period
    measure(4'b0001);
    expectWin("R10 old settings kept", 37, 0, 0, 0);
    syncStart();
    measure(4'b1111);
    expectWin("R10 new settings applied", 64, 0, 0, 10);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    testReset();
    testSingle();
    testDutyEdges();
    testBridges();
    testHalf();
    testPolarity();
    testShadow();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

endmodule